// File: doc/BRIEF.md
# I2C Line Deglitcher

This block cleans up the SCL and SDA inputs of an I2C controller. Both inputs are already synchronised. The block runs on the controller's functional clock. A level change on a line reaches the filtered output only after the raw line has held the new level for a programmed number of consecutive clock cycles. Any shorter pulse is removed. A 3-bit selection field sets the suppression length, using a nonlinear code. Code zero switches the filter off, and the raw lines pass straight through.

Whenever the filter is active, every edge it passes is late by the programmed length. The block therefore reports the length it is currently applying, and the controller's timing logic adds that figure to its transaction-time budget. When a packet starts, the controller pulses a start indication. For that cycle and the next three cycles the lines bypass the filter. Filtering then resumes automatically.

Top module: `i2c_line_deglitch`

## Requirements
- R1: The select code maps to a suppression length as follows: 0→0 (bypass), 1→1, 2→2, 3→3, 4→4, 5→8, 6→16, 7→31 cycles. `dlyCycles` shows the applied length, and shows 0 whenever the lines are bypassed.
- R2: When `filtSel` is 0, `sclOut` and `sdaOut` equal `sclRaw` and `sdaRaw` in the same cycle, with no register in the path.
- R3: When the length is N>0, an input level that is sampled on N consecutive rising edges appears at the output on the N-th of those edges. Every passed edge is therefore late by N cycles.
- R4: When the length is N>0, a pulse sampled on fewer than N consecutive edges leaves the output unchanged. A return to the current output level restarts the count.
- R5: SCL and SDA are filtered independently, with the same length. A pulse on one line has no effect on the other output.
- R6: While `rstN` is low, the filter state holds both lines high and all counts are clear. With a nonzero code and both inputs low through reset, both outputs stay high for N−1 edges after release and fall on edge N.
- R7: A change of `filtSel` discards any partial count, and the new length applies from the edge where the change is first seen. That edge counts as the first sample. No output edge is produced by the change itself.
- R8: When `pktStart` is high in a cycle, the lines bypass the filter in that cycle and in the three cycles after its rising edge, and `dlyCycles` reads 0. Filtering with the programmed length resumes on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I2C functional clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclRaw | input | 1 | Synchronised SCL input |
| sdaRaw | input | 1 | Synchronised SDA input |
| filtSel | input | 3 | Suppression length code (0 = bypass) |
| pktStart | input | 1 | One-cycle indication that a packet begins |
| sclOut | output | 1 | Filtered SCL |
| sdaOut | output | 1 | Filtered SDA |
| dlyCycles | output | 5 | Latency currently added by the filter, in cycles |

## Verification
A per-line counter that is off by one moves the output edge one cycle early or late. It also lets a pulse of exactly N−1 or N cycles through, or suppresses it, in the first pulse where the margin matters. Sweeping every code against pulse widths around the threshold exposes such a fault within one pulse. A count that survives a code change makes the output switch at the very edge where the code changes, instead of N cycles later. An arming counter with the wrong reload value shows on `dlyCycles`, and on a pass-through glitch, within four cycles of `pktStart`.

// File: rtl/i2c_deglitch_pkg.sv
package i2c_deglitch_pkg;

  localparam int SEL_W = 3;
  localparam int CNT_W = 5;

  typedef struct packed {
    logic             passThru;
    logic             restart;
    logic [CNT_W-1:0] limit;
  } dgStrobes_t;

  function automatic logic [CNT_W-1:0] decodeSel(input logic [SEL_W-1:0] code);
    logic [CNT_W-1:0] len;
    case (code)
      3'd5:    len = CNT_W'(8);
      3'd6:    len = CNT_W'(16);
      3'd7:    len = CNT_W'(31);
      default: len = CNT_W'(code);
    endcase
    return len;
  endfunction

endpackage

// File: rtl/dg_ctrl.sv
module dg_ctrl
  import i2c_deglitch_pkg::*;
#(
  parameter int ARM_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selIn,
  input  logic             pktStart,
  output dgStrobes_t       strobes,
  output logic [CNT_W-1:0] latency
);
  localparam int ARM_W = $clog2(ARM_CYCLES + 1);

  logic [SEL_W-1:0] selPrev;
  logic [ARM_W-1:0] armCnt;
  logic [CNT_W-1:0] limit;
  logic             passThru;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev <= '0;
      armCnt  <= '0;
    end else begin
      selPrev <= selIn;
      if (pktStart)
        armCnt <= ARM_W'(ARM_CYCLES);
      else if (armCnt != '0)
        armCnt <= armCnt - 1'b1;
    end
  end

  always_comb begin
    limit            = decodeSel(selIn);
    passThru         = (selIn == '0) || pktStart || (armCnt != '0);
    strobes.passThru = passThru;
    strobes.restart  = (selIn != selPrev);
    strobes.limit    = limit;
    latency          = passThru ? '0 : limit;
  end

endmodule

// File: rtl/dg_lane.sv
module dg_lane
  import i2c_deglitch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rawIn,
  input  dgStrobes_t strobes,
  output logic       filtOut
);
  logic             held;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] base;
  logic [CNT_W:0]   nextCnt;

  always_comb begin
    base    = strobes.restart ? '0 : cnt;
    nextCnt = {1'b0, base} + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held <= 1'b1;
      cnt  <= '0;
    end else if (strobes.passThru) begin
      held <= rawIn;
      cnt  <= '0;
    end else if (rawIn == held) begin
      cnt <= '0;
    end else if (nextCnt >= {1'b0, strobes.limit}) begin
      held <= rawIn;
      cnt  <= '0;
    end else begin
      cnt <= nextCnt[CNT_W-1:0];
    end
  end

  assign filtOut = strobes.passThru ? rawIn : held;

endmodule

// File: rtl/i2c_line_deglitch.sv
module i2c_line_deglitch
  import i2c_deglitch_pkg::*;
#(
  parameter int ARM_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclRaw,
  input  logic             sdaRaw,
  input  logic [SEL_W-1:0] filtSel,
  input  logic             pktStart,
  output logic             sclOut,
  output logic             sdaOut,
  output logic [CNT_W-1:0] dlyCycles
);
  localparam int LANES = 2;

  dgStrobes_t       strobes;
  logic [LANES-1:0] rawBus;
  logic [LANES-1:0] outBus;

  assign rawBus = {sdaRaw, sclRaw};

  dg_ctrl #(.ARM_CYCLES(ARM_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .selIn    (filtSel),
    .pktStart (pktStart),
    .strobes  (strobes),
    .latency  (dlyCycles)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dg_lane u_lane (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (rawBus[g]),
      .strobes (strobes),
      .filtOut (outBus[g])
    );
  end

  assign sclOut = outBus[0];
  assign sdaOut = outBus[1];

endmodule

// File: rtl/i2c_line_deglitch_sva.sv
module i2c_line_deglitch_sva (
  input logic       clk,
  input logic       rstN,
  input logic       sclRaw,
  input logic       sdaRaw,
  input logic [2:0] filtSel,
  input logic       pktStart,
  input logic       sclOut,
  input logic       sdaOut,
  input logic [4:0] dlyCycles
);

  p_legal_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    dlyCycles inside {5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd8, 5'd16, 5'd31});

  p_bypass_wire_r2: assert property (@(posedge clk) disable iff (!rstN)
    (filtSel == 3'd0) |-> (sclOut == sclRaw && sdaOut == sdaRaw));

  p_edge_source_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sclOut != $past(sclOut) && dlyCycles != 5'd0 && $past(dlyCycles) != 5'd0)
      |-> (sclOut == $past(sclRaw)));

  p_hold_level_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dlyCycles != 5'd0 && $past(dlyCycles) != 5'd0 && $past(sdaRaw) == $past(sdaOut))
      |-> (sdaOut == $past(sdaOut)));

  p_start_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    pktStart |-> (sclOut == sclRaw && sdaOut == sdaRaw && dlyCycles == 5'd0));

  p_start_arm_r8: assert property (@(posedge clk) disable iff (!rstN)
    pktStart |=> (dlyCycles == 5'd0));

endmodule

bind i2c_line_deglitch i2c_line_deglitch_sva u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .sclRaw    (sclRaw),
  .sdaRaw    (sdaRaw),
  .filtSel   (filtSel),
  .pktStart  (pktStart),
  .sclOut    (sclOut),
  .sdaOut    (sdaOut),
  .dlyCycles (dlyCycles)
);

// File: tb/i2c_line_deglitch_test.sv
`timescale 1ns/1ps
module i2c_line_deglitch_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       sclRaw, sdaRaw, pktStart;
  logic [2:0] filtSel;
  logic       sclOut, sdaOut;
  logic [4:0] dlyCycles;

  int  vecs = 0;
  int  errs = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  i2c_line_deglitch uut (
    .clk(clk), .rstN(rstN), .sclRaw(sclRaw), .sdaRaw(sdaRaw),
    .filtSel(filtSel), .pktStart(pktStart),
    .sclOut(sclOut), .sdaOut(sdaOut), .dlyCycles(dlyCycles)
  );

  function automatic int expLen(input int c);
    if (c < 5) return c;
    if (c == 7) return 31;
    return 1 << (c - 2);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

  initial begin
    rstN = 1'b0; pktStart = 1'b0; filtSel = 3'd3;
    sclRaw = 1'b0; sdaRaw = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R6: reset state holds both lines high; R1 latency for code 3
    chk("R6 scl in reset", sclOut, 1);
    chk("R6 sda in reset", sdaOut, 1);
    chk("R1 latency code3", dlyCycles, 3);
    rstN = 1'b1;
    tick(); chk("R6 scl edge1", sclOut, 1); chk("R6 sda edge1", sdaOut, 1);
    tick(); chk("R6 scl edge2", sclOut, 1); chk("R6 sda edge2", sdaOut, 1);
    tick(); chk("R6 scl edge3", sclOut, 0); chk("R6 sda edge3", sdaOut, 0);
    sclRaw = 1'b1; sdaRaw = 1'b1;
    repeat (5) tick();

    // R1: code-to-length table
    for (int c = 0; c < 8; c++) begin
      filtSel = 3'(c);
      #1;
      chk($sformatf("R1 latency code%0d", c), dlyCycles, expLen(c));
    end

    // R2: bypass is a wire
    filtSel = 3'd0;
    for (int i = 0; i < 16; i++) begin
      sclRaw = i[0]; sdaRaw = i[1];
      #1;
      chk("R2 scl bypass", sclOut, int'(sclRaw));
      chk("R2 sda bypass", sdaOut, int'(sdaRaw));
      if (i[2]) tick();
    end
    sclRaw = 1'b1; sdaRaw = 1'b1;
    tick(); tick();

    // R3/R4/R5: every code against pulse widths around the threshold
    for (int c = 1; c < 8; c++) begin
      int n;
      n = expLen(c);
      filtSel = 3'(c);
      tick(); tick();
      for (int w = 1; w <= n + 1; w++) begin
        int w2, last;
        w2 = ((w * 3) % (n + 1)) + 1;
        last = ((w > w2) ? w : w2) + n + 2;
        for (int i = 1; i <= last; i++) begin
          int eScl, eSda;
          sclRaw = (i <= w)  ? 1'b0 : 1'b1;
          sdaRaw = (i <= w2) ? 1'b0 : 1'b1;
          tick();
          eScl = (w  >= n && i >= n && i <= w  + n - 1) ? 0 : 1;
          eSda = (w2 >= n && i >= n && i <= w2 + n - 1) ? 0 : 1;
          chk((w >= n) ? "R3 scl delayed edge" : "R4 scl pulse removed", sclOut, eScl);
          chk("R5 sda independent", sdaOut, eSda);
        end
      end
    end

    // R7: code change restarts the count
    filtSel = 3'd7;
    sclRaw = 1'b1; sdaRaw = 1'b1;
    tick(); tick();
    sclRaw = 1'b0;
    for (int i = 1; i <= 20; i++) begin
      tick();
      chk("R7 scl counting", sclOut, 1);
    end
    filtSel = 3'd5;
    for (int i = 21; i <= 28; i++) begin
      tick();
      chk("R7 scl after change", sclOut, (i >= 28) ? 0 : 1);
      chk("R7 sda untouched", sdaOut, 1);
    end
    chk("R7 latency new code", dlyCycles, 8);
    sclRaw = 1'b1;
    repeat (10) tick();

    // R8: packet start opens a pass-through window
    filtSel = 3'd4;
    tick(); tick();
    pktStart = 1'b1;
    #1;
    chk("R8 latency at start", dlyCycles, 0);
    tick();
    pktStart = 1'b0;
    sclRaw = 1'b0;
    #1;
    chk("R8 scl passes glitch", sclOut, 0);
    chk("R8 latency window", dlyCycles, 0);
    tick();
    sclRaw = 1'b1;
    #1;
    chk("R8 scl passes release", sclOut, 1);
    tick();
    chk("R8 latency late window", dlyCycles, 0);
    tick();
    chk("R8 latency restored", dlyCycles, 4);
    sclRaw = 1'b0;
    tick();
    chk("R8 filtered again", sclOut, 1);
    sclRaw = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R8 glitch removed", sclOut, 1);
    end

    done = 1;
    report();
  end

endmodule